// File: doc/BRIEF.md
# Idle Receive Clock Gating Controller

This block sits between a free-running receive clock and the MAC-side receive interface. When gating is allowed, it holds the clock it delivers to the MAC low while no frame is arriving, which saves switching power in the receive path. The frame-valid strobe and the nibble data pass through one register stage. The undelayed strobe therefore acts as an early wake request, and the MAC-side clock comes back one cycle before the MAC sees valid rise. After valid falls, the clock keeps running for a fixed tail of cycles before it stops again.

Gating needs four mode inputs at once: the gating enable, the fast (100BASE-TX) line mode, loopback off and PCS bypass off. If any of these does not hold, the clock runs without a break. The mode inputs are registered, and the registers clear on reset, so after reset gating is off. The enable for each clock high phase is captured while the source clock is low. The gated clock is the AND of the source clock and that captured enable, so a high phase is always either complete or absent.

Top module: `rx_clk_idle_gate`

## Requirements
- R1: While reset is asserted and after it is released, the mode registers read as cleared: gating is off, every rising edge of clk_i gives a full pulse on rx_clk_o, and rx_dv_o and rx_data_o are 0 during reset.
- R2: rx_dv_o and rx_data_o equal rx_dv_i and rx_data_i as sampled at the previous rising edge of clk_i.
- R3: The mode inputs are sampled at each rising edge of clk_i. The high phase that follows edge n is gated by the modes sampled at edge n-1.
- R4: Gating is in effect when the sampled modes give gate_en_i=1, fast_mode_i=1, loopback_i=0 and bypass_i=0. In that state, with rx_dv_i low and no tail left, rx_clk_o stays low for the whole cycle.
- R5: When rx_dv_i is 1 at rising edge n, rx_clk_o carries a pulse at edge n. That is one pulse before edge n+1, the first edge at which rx_dv_o reads 1.
- R6: After the last edge that samples rx_dv_i high, exactly TAIL pulses follow (default 64), beginning with the edge at which rx_dv_o falls. Then the clock stops.
- R7: If rx_dv_i rises again before the tail has run out, the tail restarts from its full length and no pulse is dropped.
- R8: While loopback is sampled active, every edge gives a pulse.
- R9: While PCS bypass is sampled active, every edge gives a pulse.
- R10: While the fast line mode is not selected, every edge gives a pulse, even with gate_en_i set.
- R11: rx_clk_o is low whenever clk_i is low. clk_en_o changes only while clk_i is low and shows whether the current high phase is passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_en_i | input | 1 | Gating enable |
| fast_mode_i | input | 1 | 1 when the line runs in 100BASE-TX mode |
| loopback_i | input | 1 | Loopback active; forces the clock to run |
| bypass_i | input | 1 | PCS bypass active; forces the clock to run |
| rx_dv_i | input | 1 | Undelayed frame-valid strobe (early wake) |
| rx_data_i | input | DW | Undelayed receive data |
| rx_dv_o | output | 1 | Frame-valid strobe, one cycle late |
| rx_data_o | output | DW | Receive data, one cycle late |
| clk_en_o | output | 1 | Enable captured for the current high phase |
| rx_clk_o | output | 1 | Gated receive clock |

## Verification
A tail counter that loads wrong or counts wrong shows at the ports as a pulse train after the fall of rx_dv_o that is too short or too long. The bench catches it at the first missing or extra pulse, and counts the pulses against its own tally of TAIL. A wrong mode register shows as a pulse that appears or disappears two edges after the mode input changes. A missed early wake shows as a silent edge in the same cycle that rx_dv_i is sampled high. The bench compares the pulse presence, the delayed strobe and the data on every cycle, and checks on every low phase that rx_clk_o is low. A fault therefore shows within one cycle of the first point where it changes the port behaviour.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

   typedef struct packed {
      logic gate_en;
      logic fast;
      logic loopback;
      logic bypass;
   } rxg_mode_t;

   function automatic logic rxg_may_gate(input rxg_mode_t m);
      return m.gate_en & m.fast & ~m.loopback & ~m.bypass;
   endfunction

endpackage

// File: rtl/rxg_mode_ctrl.sv
module rxg_mode_ctrl
   import rxg_pkg::*;
#(
   parameter bit MODE_REG = 1'b1
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  rxg_mode_t mode_d_i,
   output logic      force_run_o
);

   rxg_mode_t mode_q;

   generate
      if (MODE_REG) begin : g_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) mode_q <= '0;
            else         mode_q <= mode_d_i;
         end
      end else begin : g_direct
         assign mode_q = mode_d_i;
      end
   endgenerate

   assign force_run_o = ~rxg_may_gate(mode_q);

endmodule

// File: rtl/rxg_tail_timer.sv
module rxg_tail_timer #(
   parameter int TAIL = 64,
   localparam int CW = $clog2(TAIL + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wake_i,
   output logic          busy_o,
   output logic [CW-1:0] cnt_o
);

   localparam logic [CW-1:0] LOAD = CW'(TAIL);

   initial begin
      if (TAIL < 1) $error("rxg_tail_timer: TAIL must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (wake_i)          cnt_q <= LOAD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
   assign cnt_o  = cnt_q;

   // R7: a wake during the tail reloads the full length
   a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_i |=> (cnt_q == LOAD));

   // R6: without a wake the tail counts down by one per edge
   a_r6_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wake_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rxg_rx_pipe.sv
module rxg_rx_pipe #(
   parameter int DW = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          dv_i,
   input  logic [DW-1:0] data_i,
   output logic          dv_o,
   output logic [DW-1:0] data_o
);

   initial begin
      if (DW < 1) $error("rxg_rx_pipe: DW must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dv_o   <= 1'b0;
         data_o <= '0;
      end else begin
         dv_o   <= dv_i;
         data_o <= data_i;
      end
   end

   // R2: the strobe leaves one edge after it arrives
   a_r2_dv_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (dv_o == $past(dv_i)));

endmodule

// File: rtl/rxg_clk_gate.sv
module rxg_clk_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_d_i,
   output logic en_o,
   output logic gclk_o
);

   logic en_lat;

   // enable moves only while clk_i is low, so no high phase is cut
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_lat <= 1'b1;
      else         en_lat <= en_d_i;
   end

   assign en_o   = en_lat;
   assign gclk_o = clk_i & en_lat;

endmodule

// File: rtl/rx_clk_idle_gate.sv
module rx_clk_idle_gate
   import rxg_pkg::*;
#(
   parameter int DW       = 4,
   parameter int TAIL     = 64,
   parameter bit MODE_REG = 1'b1,
   localparam int CW      = $clog2(TAIL + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          gate_en_i,
   input  logic          fast_mode_i,
   input  logic          loopback_i,
   input  logic          bypass_i,
   input  logic          rx_dv_i,
   input  logic [DW-1:0] rx_data_i,
   output logic          rx_dv_o,
   output logic [DW-1:0] rx_data_o,
   output logic          clk_en_o,
   output logic          rx_clk_o
);

   rxg_mode_t     mode_d;
   logic          force_run;
   logic          tail_busy;
   logic [CW-1:0] tail_cnt;
   logic          run_req;

   assign mode_d = '{gate_en: gate_en_i, fast: fast_mode_i,
                     loopback: loopback_i, bypass: bypass_i};

   rxg_mode_ctrl #(.MODE_REG(MODE_REG)) u_mode (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_d_i    (mode_d),
      .force_run_o (force_run)
   );

   rxg_tail_timer #(.TAIL(TAIL)) u_tail (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wake_i (rx_dv_i),
      .busy_o (tail_busy),
      .cnt_o  (tail_cnt)
   );

   rxg_rx_pipe #(.DW(DW)) u_pipe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .dv_i   (rx_dv_i),
      .data_i (rx_data_i),
      .dv_o   (rx_dv_o),
      .data_o (rx_data_o)
   );

   // the undelayed strobe wakes the clock ahead of the delayed one
   assign run_req = force_run | rx_dv_i | tail_busy;

   rxg_clk_gate u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_d_i (run_req),
      .en_o   (clk_en_o),
      .gclk_o (rx_clk_o)
   );

   // R5: an incoming strobe already has its pulse at this edge
   a_r5_wake_ahead: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_dv_i |-> clk_en_o);

   // R8: loopback keeps the clock running
   a_r8_loopback_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(loopback_i) |-> clk_en_o);

   // R9: bypass keeps the clock running
   a_r9_bypass_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(bypass_i) |-> clk_en_o);

   // R10: outside the fast mode the clock keeps running
   a_r10_slow_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(fast_mode_i) |-> clk_en_o);

   // R4: idle with gating in effect gives no pulse
   a_r4_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!force_run && !rx_dv_i && tail_cnt == '0) |-> !clk_en_o);

endmodule

// File: tb/sim_rx_clk_idle_gate.sv
module sim_rx_clk_idle_gate;

   localparam int DW   = 4;
   localparam int TAIL = 64;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic gate_en_i = 0, fast_mode_i = 0, loopback_i = 0, bypass_i = 0;
   logic rx_dv_i = 0;
   logic [DW-1:0] rx_data_i = '0;
   logic rx_dv_o, clk_en_o, rx_clk_o;
   logic [DW-1:0] rx_data_o;

   always #10 clk = ~clk;   // 50 MHz

   rx_clk_idle_gate #(.DW(DW), .TAIL(TAIL)) u0 (
      .clk_i(clk), .rst_ni(rst_ni), .gate_en_i(gate_en_i),
      .fast_mode_i(fast_mode_i), .loopback_i(loopback_i), .bypass_i(bypass_i),
      .rx_dv_i(rx_dv_i), .rx_data_i(rx_data_i), .rx_dv_o(rx_dv_o),
      .rx_data_o(rx_data_o), .clk_en_o(clk_en_o), .rx_clk_o(rx_clk_o)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   bit    run = 0;
   string cur = "R1";
   logic [7:0] lfsr = 8'h5a;

   // reference model state
   bit m_en = 0, m_fast = 0, m_lb = 0, m_byp = 0;
   int tcnt = 0;
   bit e_pulse, e_dv;
   logic [DW-1:0] e_data;

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
      end
   endtask

   task automatic check_d(input string req, input logic [DW-1:0] act,
                          input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (run) begin
         e_pulse = !(m_en && m_fast && !m_lb && !m_byp) || rx_dv_i || (tcnt > 0);
         e_dv    = rx_dv_i;
         e_data  = rx_data_i;
         if (rx_dv_i) tcnt = TAIL;
         else if (tcnt > 0) tcnt = tcnt - 1;
         m_en = gate_en_i; m_fast = fast_mode_i;
         m_lb = loopback_i; m_byp = bypass_i;
         #5;
         check(cur, rx_clk_o, e_pulse);
         check("R11", clk_en_o, e_pulse);
         check("R2", rx_dv_o, e_dv);
         check_d("R2", rx_data_o, e_data);
      end
   end

   always @(negedge clk) begin
      if (run) begin
         #5;
         check("R11", rx_clk_o, 1'b0);
      end
   end

   task automatic drive(input logic dv, input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
         rx_dv_i   = dv;
         rx_data_i = lfsr[DW-1:0];
         lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
   endtask

   task automatic modes(input logic en, input logic fast, input logic lb,
                        input logic byp);
      @(posedge clk);
      #1;
      gate_en_i = en; fast_mode_i = fast; loopback_i = lb; bypass_i = byp;
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state, clock passes during reset
      repeat (2) @(posedge clk);
      #5;
      check("R1", rx_clk_o, 1'b1);
      check("R1", rx_dv_o, 1'b0);
      check_d("R1", rx_data_o, '0);
      @(negedge clk); #5;
      check("R1", rx_clk_o, 1'b0);
      @(posedge clk); #1;
      rst_ni = 1'b1;
      run = 1;
      cur = "R1";
      drive(0, 5);
      // R10: enable set but slow line mode
      cur = "R10";
      modes(1, 0, 0, 0);
      drive(0, 6);
      // R4: gating in effect, idle
      cur = "R4";
      modes(1, 1, 0, 0);
      drive(0, 10);
      // R5: frame wakes the clock one pulse early
      cur = "R5";
      drive(1, 8);
      // R6: tail of TAIL pulses then stop
      cur = "R6";
      drive(0, TAIL + 12);
      // R7: strobe returns inside the tail
      cur = "R7";
      drive(1, 4);
      drive(0, 30);
      drive(1, 3);
      drive(0, TAIL + 8);
      // R8: loopback forces running
      cur = "R8";
      modes(1, 1, 1, 0);
      drive(0, 10);
      modes(1, 1, 0, 0);
      drive(0, 6);
      // R9: bypass forces running
      cur = "R9";
      modes(1, 1, 0, 1);
      drive(0, 10);
      modes(1, 1, 0, 0);
      drive(0, 6);
      // R3: enable toggled, one edge of mode latency
      cur = "R3";
      modes(0, 1, 0, 0);
      drive(0, 5);
      modes(1, 1, 0, 0);
      drive(0, 5);
      drive(1, 2);
      modes(0, 1, 0, 0);
      drive(0, 4);
      modes(1, 1, 0, 0);
      drive(0, TAIL + 6);
      @(posedge clk); #8;
      run = 0;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule